// File: doc/BRIEF.md
# Prescaled 8-bit PWM generator

This block drives one pulse-width-modulated output from a single 32-bit control word. Software writes the word over a simple synchronous port and can read it back unchanged at any time, so read-modify-write sequences that touch only the timing fields keep the run and idle-level bits intact. While running, a prescaler divides the input clock by a programmable divisor to produce a tick, and an 8-bit tick counter sweeps 0 to 255, giving a period of 256 ticks. The low part of each period is set by the duty field. The active part is the rest.

A two-state controller sequences the block. In `ST_IDLE` the prescaler and tick counter are held at zero, the divisor and duty fields are copied into shadow registers every cycle, and the output shows the programmed idle level. The transition `IDLE_TO_RUN` happens on the first clock edge at which the stored run bit is 1. The transition `RUN_TO_IDLE` happens on the first edge at which it is 0. In `ST_RUN` the shadows reload only when the tick counter wraps from 255 to 0, so a rewrite of the timing fields never cuts a period short. A period already under way finishes with the old values.

Control word layout: bit 31 is the run bit, bit 30 is the idle level, bits 15:8 are the divisor (reload) field, and bits 7:0 are the duty field. All other bits are stored and read back but have no effect.

Top module: `pwm8_prescaled`

## Requirements
- R1: After a write, `rd_data` returns all 32 written bits unchanged from the following cycle onward, including bits that have no function.
- R2: While the controller is in `ST_IDLE`, `pwm_out` equals bit 30 of the control word. Because reset clears that bit, the idle output after reset is low.
- R3: The divisor field (bits 15:8) with value N divides the clock by N when N is 1 to 255, and by 256 when N is 0. One tick occurs every divisor cycles, and one PWM period lasts 256 times the divisor clock cycles.
- R4: In `ST_RUN`, `pwm_out` is 0 while the tick count is below the duty shadow value taken from bits 7:0, and 1 otherwise. A duty of 0 therefore gives a constant 1, and a duty of D gives 256-D active ticks per period.
- R5: On `IDLE_TO_RUN`, both the prescaler and the tick counter start from zero. The first cycle in `ST_RUN` is cycle 0 of a fresh period.
- R6: In `ST_RUN`, a change to the divisor or duty field first takes effect in the cycle after the tick counter wraps from 255 to 0. The rest of the current period still uses the old values.
- R7: `IDLE_TO_RUN` occurs one clock after the run bit (bit 31) reads 1, and `RUN_TO_IDLE` occurs one clock after it reads 0. In `ST_IDLE`, the prescaler and tick counter are held at zero.
- R8: `rst` is synchronous and active high. It clears the whole control word to zero and returns the controller to `ST_IDLE`, so `pwm_out` is 0 and `rd_data` is 0 after a reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value loaded into the control word when `wr_en` is high |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded assertions watch the following on every cycle:
- register readback after each write;
- the idle level while stopped;
- the prescaler staying inside its divisor;
- single-step counting on ticks;
- shadows that hold still between wraps;
- zero counters at the start of a run;
- the constant-high output at duty 0;
- the two controller transitions.

Only the bench's scenarios can show whole waveforms. These include the exact active-tick count and edge position of each period across a full sweep of duty values, the divide-by-256 encoding of a zero divisor, and a mid-period rewrite that takes hold exactly at the following wrap.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    localparam int CTRL_W   = 32;
    localparam int RUN_POS  = 31;
    localparam int IDLE_POS = 30;
    localparam int FIELD_W  = 8;
    localparam int DIV_LSB  = 8;
    localparam int DUTY_LSB = 0;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_e;
endpackage

// File: rtl/pwm8_ctrl_reg.sv
module pwm8_ctrl_reg #(
    parameter int CTRL_W   = 32,
    parameter int RUN_POS  = 31,
    parameter int IDLE_POS = 30,
    parameter int FIELD_W  = 8,
    parameter int DIV_LSB  = 8,
    parameter int DUTY_LSB = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CTRL_W-1:0]  wr_data,
    output logic [CTRL_W-1:0]  word_q,
    output logic               run_req,
    output logic               idle_lvl,
    output logic [FIELD_W-1:0] div_fld,
    output logic [FIELD_W-1:0] duty_fld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_data;
        end
    end

    always_comb begin
        run_req  = word_q[RUN_POS];
        idle_lvl = word_q[IDLE_POS];
        div_fld  = word_q[DIV_LSB +: FIELD_W];
        duty_fld = word_q[DUTY_LSB +: FIELD_W];
    end

    assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (word_q == $past(wr_data)));

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(word_q));
endmodule

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] div_sh,
    output logic [W-1:0] pre_q,
    output logic         tick
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] last_cnt;
    logic [W-1:0] pre_d;

    // divisor N counts 0..N-1; N = 0 wraps to all ones -> 2**W
    always_comb begin
        last_cnt = div_sh - ONE;
        tick     = run && (pre_q == last_cnt);
        if (clear || tick) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = pre_q + ONE;
        end else begin
            pre_d = pre_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assert_pre_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (pre_q <= W'(div_sh - ONE)));

    assert_pre_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pre_q == '0));
endmodule

// File: rtl/pwm8_period_cnt.sv
module pwm8_period_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] duty_sh,
    output logic [W-1:0] cnt_q,
    output logic         wrap,
    output logic         active
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d;

    always_comb begin
        wrap   = tick && (cnt_q == TOP);
        active = (cnt_q >= duty_sh);
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear) |=> (cnt_q == W'($past(cnt_q) + ONE)));

    assert_cnt_still_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt_q));

    assert_cnt_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/pwm8_seq_fsm.sv
module pwm8_seq_fsm
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_req,
    input  logic         idle_lvl,
    input  logic [W-1:0] div_fld,
    input  logic [W-1:0] duty_fld,
    input  logic         wrap,
    input  logic         active,
    output logic         run,
    output logic         clear,
    output logic [W-1:0] div_sh,
    output logic [W-1:0] duty_sh,
    output logic         pwm_out
);
    pwm_state_e state_q;
    pwm_state_e state_d;
    logic       load_sh;

    // next state: IDLE_TO_RUN and RUN_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_req)  state_d = ST_RUN;
            ST_RUN:  if (!run_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // shadows follow the fields while idle, else only at a wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            div_sh  <= '0;
            duty_sh <= '0;
        end else if (load_sh) begin
            div_sh  <= div_fld;
            duty_sh <= duty_fld;
        end
    end

    always_comb begin
        run     = 1'b0;
        clear   = 1'b0;
        load_sh = 1'b0;
        pwm_out = idle_lvl;
        unique case (state_q)
            ST_IDLE: begin
                clear   = 1'b1;
                load_sh = 1'b1;
                pwm_out = idle_lvl;
            end
            ST_RUN: begin
                run     = 1'b1;
                load_sh = wrap;
                pwm_out = active;
            end
            default: begin
                clear = 1'b1;
            end
        endcase
    end

    assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!run_req) |-> (pwm_out == idle_lvl));

    assert_to_run_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && run_req) |=> (state_q == ST_RUN));

    assert_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !run_req) |=> (state_q == ST_IDLE));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !wrap) |=> ($stable(duty_sh) && $stable(div_sh)));
endmodule

// File: rtl/pwm8_prescaled.sv
module pwm8_prescaled
    import pwm8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              pwm_out
);
    logic               run_req;
    logic               idle_lvl;
    logic [FIELD_W-1:0] div_fld;
    logic [FIELD_W-1:0] duty_fld;
    logic               run;
    logic               clear;
    logic [FIELD_W-1:0] div_sh;
    logic [FIELD_W-1:0] duty_sh;
    logic [FIELD_W-1:0] pre_q;
    logic               tick;
    logic [FIELD_W-1:0] cnt_q;
    logic               wrap;
    logic               active;

    pwm8_ctrl_reg #(
        .CTRL_W  (CTRL_W),
        .RUN_POS (RUN_POS),
        .IDLE_POS(IDLE_POS),
        .FIELD_W (FIELD_W),
        .DIV_LSB (DIV_LSB),
        .DUTY_LSB(DUTY_LSB)
    ) reg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .word_q  (rd_data),
        .run_req (run_req),
        .idle_lvl(idle_lvl),
        .div_fld (div_fld),
        .duty_fld(duty_fld)
    );

    pwm8_seq_fsm #(.W(FIELD_W)) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .run_req (run_req),
        .idle_lvl(idle_lvl),
        .div_fld (div_fld),
        .duty_fld(duty_fld),
        .wrap    (wrap),
        .active  (active),
        .run     (run),
        .clear   (clear),
        .div_sh  (div_sh),
        .duty_sh (duty_sh),
        .pwm_out (pwm_out)
    );

    pwm8_prescaler #(.W(FIELD_W)) pre_i (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .run   (run),
        .div_sh(div_sh),
        .pre_q (pre_q),
        .tick  (tick)
    );

    pwm8_period_cnt #(.W(FIELD_W)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .tick   (tick),
        .duty_sh(duty_sh),
        .cnt_q  (cnt_q),
        .wrap   (wrap),
        .active (active)
    );

    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (cnt_q == '0 && pre_q == '0));

    assert_duty_zero_high_R4: assert property (@(posedge clk) disable iff (rst)
        (run && duty_sh == '0) |-> pwm_out);

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !pwm_out));
endmodule

// File: tb/pwm8_prescaled_tb_top.sv
module pwm8_prescaled_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwm8_prescaled dut_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    function automatic logic [31:0] mk(input bit en, input bit idl,
                                       input int rl, input int dt);
        return {en, idl, 14'h0, rl[7:0], dt[7:0]};
    endfunction

    function automatic int eff_div(input int rl);
        return (rl == 0) ? 256 : rl;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // restart with the given fields, then compare one or more periods cycle by cycle
    task automatic run_periods(input int rl, input int dt, input int nper, input string req);
        int dv;
        int bad;
        int first_bad;
        int exp_hi;
        int hi;
        dv  = eff_div(rl);
        bad = 0;
        first_bad = -1;
        hi = 0;
        reg_write(mk(0, 0, rl, dt));
        reg_write(mk(1, 0, rl, dt));
        for (int i = 0; i < 256 * dv * nper; i++) begin
            @(negedge clk);
            if (pwm_out !== (((i % (256 * dv)) / dv) >= dt)) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
            if (pwm_out === 1'b1) hi++;
        end
        exp_hi = (256 - dt) * dv * nper;
        check(bad == 0, req, $sformatf("waveform div=%0d duty=%0d first bad cycle", dv, dt),
              first_bad, -1);
        check(hi == exp_hi, req, $sformatf("active cycles div=%0d duty=%0d", dv, dt),
              hi, exp_hi);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 195000 && !done) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 195000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int bad;
        int fb;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 / R2: reset state
        check(rd_data == 32'h0, "R8", "rd_data after reset", rd_data, 0);
        check(pwm_out == 1'b0, "R2", "idle output after reset", pwm_out, 0);

        // R1: exact readback including unused bits; R2 idle level high
        reg_write(32'h5A3C_C3A5);
        check(rd_data == 32'h5A3C_C3A5, "R1", "readback", rd_data, 32'h5A3C_C3A5);
        @(negedge clk);
        check(pwm_out == 1'b1, "R2", "idle level one", pwm_out, 1);
        reg_write(32'h0000_FF01);
        check(rd_data == 32'h0000_FF01, "R1", "readback 2", rd_data, 32'h0000_FF01);
        @(negedge clk);
        check(pwm_out == 1'b0, "R2", "idle level zero", pwm_out, 0);

        // R4 / R5: full duty sweep at divide-by-1, restart before each
        for (int d = 0; d < 256; d++) run_periods(1, d, 1, "R4");
        // R3: other divisors
        run_periods(2, 0, 1, "R3");
        run_periods(2, 64, 1, "R3");
        run_periods(2, 255, 1, "R3");
        run_periods(3, 1, 1, "R3");
        run_periods(3, 127, 2, "R3");
        run_periods(3, 255, 1, "R3");
        // R3: zero field means divide by 256
        run_periods(0, 200, 1, "R3");

        // R6: mid-period rewrite of duty and divisor
        reg_write(mk(0, 0, 1, 100));
        reg_write(mk(1, 0, 1, 100));
        bad = 0;
        fb = -1;
        for (int i = 0; i < 256 + 512; i++) begin
            @(negedge clk);
            if (i < 256) begin
                if (pwm_out !== (i >= 100)) begin bad++; if (fb < 0) fb = i; end
            end else begin
                if (pwm_out !== (((i - 256) / 2) >= 200)) begin bad++; if (fb < 0) fb = i; end
            end
            if (i == 50) begin wr_en = 1'b1; wr_data = mk(1, 0, 2, 200); end
            if (i == 51) wr_en = 1'b0;
        end
        check(bad == 0, "R6", "update at wrap first bad cycle", fb, -1);

        // R7 / R2: stop mid-period with idle high, output follows one clock later
        reg_write(mk(0, 1, 2, 200));
        check(pwm_out == 1'b0, "R7", "still running one cycle after clearing run bit",
              pwm_out, 0);
        @(negedge clk);
        check(pwm_out == 1'b1, "R7", "idle level after stop", pwm_out, 1);
        // R5: restart after a stop mid-period begins a fresh period
        run_periods(4, 10, 1, "R5");

        // R8: reset while running
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(rd_data == 32'h0, "R8", "rd_data after reset in run", rd_data, 0);
        check(pwm_out == 1'b0, "R8", "output after reset in run", pwm_out, 0);
        @(negedge clk);
        check(pwm_out == 1'b0, "R8", "output stays low", pwm_out, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule